// File: doc/BRIEF.md
# PCIe Configuration Window Decoder

This block owns the 64-bit base-address register that places the memory-mapped PCIe configuration window in the system address map, and decides for every memory address presented to it whether that address falls inside the window. Software programs the register as two consecutive dwords through a byte-enabled configuration write port. After each write that touches the register, the block derives the window enable, the window size and a size-aligned base, and holds them as the active mapping.

Each address strobe is compared against the active mapping. One cycle later the block reports a registered hit together with the bus number, device number, function number and register offset taken from the address, ready for a downstream configuration transaction engine. The bus number is narrowed to the bits the selected window size can carry. A length code that names no size is stored but not applied: the previous mapping stays active and a one-cycle error pulse is raised.

Top module: `cfgwin_decoder`

## Requirements
- R1: On reset the register takes the value DEFAULT_VAL (default 64'h0000_0000_B000_0000) and the active window is derived from it, so with defaults the window is disabled, the length code is 00 and the base is 0xB000_0000.
- R2: Register bit 0 is the window enable; bits [2:1] are the length code with 00 = 256 MiB, 01 = 128 MiB, 10 = 64 MiB and 11 = reserved; the length code shown on the window outputs is never 11.
- R3: The active base keeps register bits [BASE_MSB:28] for 256 MiB, [BASE_MSB:27] for 128 MiB and [BASE_MSB:26] for 64 MiB (BASE_MSB defaults to 35); every other base bit reads zero.
- R4: A write that leaves the length code at 11 keeps the active enable, length and base exactly as they were and raises len_err_o for one cycle.
- R5: The register is dword REG_DW (bits 31:0) and dword REG_DW+1 (bits 63:32) of the configuration space; each byte enable writes one byte lane; the active window is recomputed from the merged value at the same clock edge that stores the write.
- R6: A write that enables no byte of these two dwords changes neither the register nor the active window.
- R7: An address hits when the window is enabled, its bits from the size boundary up to BASE_MSB equal the base and its bits above BASE_MSB are zero; hit_o is asserted in the cycle after the address strobe.
- R8: No address hits while the window is disabled, and no hit is reported without an address strobe.
- R9: On a hit, bus_o is addr[27:20] with bit 7 cleared for 128 MiB and bits 7:6 cleared for 64 MiB, dev_o is addr[19:15], fn_o is addr[14:12] and reg_off_o is addr[11:0]; without a hit all four fields are zero.
- R10: len_err_o is raised only in the cycle after a write that touches the register and leaves the length code at 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_vld_i | input | 1 | Configuration write strobe |
| cfg_wr_dw_i | input | CFG_DW_AW | Dword index of the configuration write |
| cfg_wr_be_i | input | 4 | Byte enables of the configuration write |
| cfg_wr_data_i | input | 32 | Configuration write data |
| addr_vld_i | input | 1 | Memory address strobe |
| addr_i | input | ADDR_W | Memory address to decode |
| win_en_o | output | 1 | Active window enable |
| win_len_o | output | 2 | Active length code |
| win_base_o | output | ADDR_W | Active aligned window base |
| len_err_o | output | 1 | One-cycle pulse on a reserved length write |
| hit_o | output | 1 | Registered hit for the previous strobe |
| bus_o | output | 8 | Bus number of the hit |
| dev_o | output | 5 | Device number of the hit |
| fn_o | output | 3 | Function number of the hit |
| reg_off_o | output | 12 | Register offset of the hit |

## Verification
Every cycle the assertions check that a hit needs a strobe and an enabled window one cycle earlier, that the fields are zero without a hit, that the active length code is never reserved, that the base is aligned to its size, and that the window only moves after a write while an error pulse leaves it untouched. Whether the merged byte lanes, the bus truncation per size and the hit boundary at the window edges give the right values can only be shown by the bench, which compares every write and every decoded address against its own model of the register and the window under random and directed stimulus.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

   localparam int unsigned REG_W     = 64;
   localparam int unsigned DW_W      = 32;
   localparam int unsigned BE_W      = DW_W / 8;
   localparam int unsigned EN_BIT    = 0;
   localparam int unsigned LEN_LSB   = 1;
   localparam int unsigned SHIFT_MAX = 28;   // largest window, 256 MiB
   localparam int unsigned SHIFT_MIN = 26;   // smallest window, 64 MiB

   localparam int unsigned OFF_W = 12;
   localparam int unsigned FN_W  = 3;
   localparam int unsigned DEV_W = 5;
   localparam int unsigned BUS_W = 8;
   localparam int unsigned FN_LSB  = OFF_W;
   localparam int unsigned DEV_LSB = FN_LSB + FN_W;
   localparam int unsigned BUS_LSB = DEV_LSB + DEV_W;

   typedef enum logic [1:0] {
      WIN_256M = 2'b00,
      WIN_128M = 2'b01,
      WIN_64M  = 2'b10,
      WIN_RSVD = 2'b11
   } win_len_e;

   typedef struct packed {
      logic       en;
      win_len_e   len;
   } win_ctl_t;

   // number of address bits covered by a window of the given code
   function automatic int unsigned win_shift(input logic [1:0] code);
      case (code)
         WIN_256M: win_shift = SHIFT_MAX;
         WIN_128M: win_shift = SHIFT_MAX - 1;
         default:  win_shift = SHIFT_MIN;
      endcase
   endfunction

endpackage

// File: rtl/cfgwin_bar_reg.sv
module cfgwin_bar_reg
   import cfgwin_pkg::*;
#(
   parameter int unsigned          CFG_DW_AW   = 10,
   parameter int unsigned          REG_DW      = 24,
   parameter logic [REG_W-1:0]     DEFAULT_VAL = 64'h0000_0000_B000_0000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_vld_i,
   input  logic [CFG_DW_AW-1:0] wr_dw_i,
   input  logic [BE_W-1:0]      wr_be_i,
   input  logic [DW_W-1:0]      wr_data_i,
   output logic [REG_W-1:0]     bar_nxt_o,
   output logic                 touch_o
);

   localparam int unsigned N_HALF = REG_W / DW_W;
   localparam int unsigned N_LANE = N_HALF * BE_W;

   logic [REG_W-1:0]  bar_q;
   logic [N_LANE-1:0] lane_sel;

   if (REG_DW + N_HALF > (1 << CFG_DW_AW)) begin : g_bad_dw
      $error("cfgwin_bar_reg: REG_DW does not fit the configuration dword index");
   end

   for (genvar h = 0; h < N_HALF; h++) begin : g_half
      localparam logic [CFG_DW_AW-1:0] MY_DW = CFG_DW_AW'(REG_DW + h);
      logic dw_match;
      assign dw_match = wr_vld_i && (wr_dw_i == MY_DW);
      for (genvar b = 0; b < BE_W; b++) begin : g_lane
         localparam int unsigned LANE = h * BE_W + b;
         assign lane_sel[LANE] = dw_match && wr_be_i[b];
         assign bar_nxt_o[LANE*8 +: 8] = lane_sel[LANE] ? wr_data_i[b*8 +: 8]
                                                        : bar_q[LANE*8 +: 8];
      end
   end

   assign touch_o = |lane_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bar_q <= DEFAULT_VAL;
      end else if (touch_o) begin
         bar_q <= bar_nxt_o;
      end
   end

endmodule

// File: rtl/cfgwin_map.sv
module cfgwin_map
   import cfgwin_pkg::*;
#(
   parameter int unsigned      ADDR_W      = 40,
   parameter int unsigned      BASE_MSB    = 35,
   parameter logic [REG_W-1:0] DEFAULT_VAL = 64'h0000_0000_B000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              touch_i,
   input  logic [REG_W-1:0]  bar_i,
   output logic              en_o,
   output logic [1:0]        len_o,
   output logic [ADDR_W-1:0] base_o,
   output logic              err_o
);

   function automatic logic [ADDR_W-1:0] align_base(input logic [REG_W-1:0] v);
      int unsigned sh;
      logic [ADDR_W-1:0] r;
      sh = win_shift(v[LEN_LSB +: 2]);
      for (int i = 0; i < ADDR_W; i++) begin
         r[i] = (i >= int'(sh) && i <= int'(BASE_MSB)) ? v[i] : 1'b0;
      end
      return r;
   endfunction

   localparam logic [1:0]        RST_LEN  = DEFAULT_VAL[LEN_LSB +: 2];
   localparam logic              RST_EN   = DEFAULT_VAL[EN_BIT];
   localparam logic [ADDR_W-1:0] RST_BASE = align_base(DEFAULT_VAL);

   if (RST_LEN == WIN_RSVD) begin : g_bad_default
      $error("cfgwin_map: DEFAULT_VAL carries the reserved length code");
   end

   win_ctl_t          ctl_q;
   logic [ADDR_W-1:0] base_q;
   logic              err_q;
   logic              rsvd;

   assign rsvd = (bar_i[LEN_LSB +: 2] == WIN_RSVD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q.en  <= RST_EN;
         ctl_q.len <= win_len_e'(RST_LEN);
         base_q    <= RST_BASE;
         err_q     <= 1'b0;
      end else begin
         err_q <= touch_i && rsvd;
         if (touch_i && !rsvd) begin
            ctl_q.en  <= bar_i[EN_BIT];
            ctl_q.len <= win_len_e'(bar_i[LEN_LSB +: 2]);
            base_q    <= align_base(bar_i);
         end
      end
   end

   assign en_o   = ctl_q.en;
   assign len_o  = ctl_q.len;
   assign base_o = base_q;
   assign err_o  = err_q;

endmodule

// File: rtl/cfgwin_hit.sv
module cfgwin_hit
   import cfgwin_pkg::*;
#(
   parameter int unsigned ADDR_W = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_vld_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              en_i,
   input  logic [1:0]        len_i,
   input  logic [ADDR_W-1:0] base_i,
   output logic              hit_o,
   output logic [BUS_W-1:0]  bus_o,
   output logic [DEV_W-1:0]  dev_o,
   output logic [FN_W-1:0]   fn_o,
   output logic [OFF_W-1:0]  off_o
);

   int unsigned       sh;
   logic [ADDR_W-1:0] cmp_mask;
   logic [BUS_W-1:0]  bus_keep;
   logic              match;
   logic              hit_d;

   assign sh = win_shift(len_i);

   for (genvar i = 0; i < ADDR_W; i++) begin : g_cmp
      assign cmp_mask[i] = (i >= int'(sh));
   end

   for (genvar j = 0; j < BUS_W; j++) begin : g_bus
      assign bus_keep[j] = ((BUS_LSB + j) < int'(sh));
   end

   assign match = (((addr_i ^ base_i) & cmp_mask) == '0);
   assign hit_d = addr_vld_i && en_i && match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_o <= 1'b0;
         bus_o <= '0;
         dev_o <= '0;
         fn_o  <= '0;
         off_o <= '0;
      end else begin
         hit_o <= hit_d;
         if (hit_d) begin
            bus_o <= addr_i[BUS_LSB +: BUS_W] & bus_keep;
            dev_o <= addr_i[DEV_LSB +: DEV_W];
            fn_o  <= addr_i[FN_LSB +: FN_W];
            off_o <= addr_i[0 +: OFF_W];
         end else begin
            bus_o <= '0;
            dev_o <= '0;
            fn_o  <= '0;
            off_o <= '0;
         end
      end
   end

endmodule

// File: rtl/cfgwin_decoder.sv
module cfgwin_decoder
   import cfgwin_pkg::*;
#(
   parameter int unsigned      ADDR_W      = 40,
   parameter int unsigned      BASE_MSB    = 35,
   parameter int unsigned      CFG_DW_AW   = 10,
   parameter int unsigned      REG_DW      = 24,
   parameter logic [REG_W-1:0] DEFAULT_VAL = 64'h0000_0000_B000_0000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr_vld_i,
   input  logic [CFG_DW_AW-1:0] cfg_wr_dw_i,
   input  logic [3:0]           cfg_wr_be_i,
   input  logic [31:0]          cfg_wr_data_i,
   input  logic                 addr_vld_i,
   input  logic [ADDR_W-1:0]    addr_i,
   output logic                 win_en_o,
   output logic [1:0]           win_len_o,
   output logic [ADDR_W-1:0]    win_base_o,
   output logic                 len_err_o,
   output logic                 hit_o,
   output logic [7:0]           bus_o,
   output logic [4:0]           dev_o,
   output logic [2:0]           fn_o,
   output logic [11:0]          reg_off_o
);

   if (BASE_MSB < SHIFT_MAX || BASE_MSB >= ADDR_W) begin : g_bad_msb
      $error("cfgwin_decoder: BASE_MSB must lie between the window size and ADDR_W");
   end
   if (ADDR_W > REG_W) begin : g_bad_aw
      $error("cfgwin_decoder: ADDR_W exceeds the register width");
   end

   logic [REG_W-1:0] bar_nxt;
   logic             touch;

   cfgwin_bar_reg #(
      .CFG_DW_AW   (CFG_DW_AW),
      .REG_DW      (REG_DW),
      .DEFAULT_VAL (DEFAULT_VAL)
   ) u_bar (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_vld_i  (cfg_wr_vld_i),
      .wr_dw_i   (cfg_wr_dw_i),
      .wr_be_i   (cfg_wr_be_i),
      .wr_data_i (cfg_wr_data_i),
      .bar_nxt_o (bar_nxt),
      .touch_o   (touch)
   );

   cfgwin_map #(
      .ADDR_W      (ADDR_W),
      .BASE_MSB    (BASE_MSB),
      .DEFAULT_VAL (DEFAULT_VAL)
   ) u_map (
      .clk     (clk),
      .rst_n   (rst_n),
      .touch_i (touch),
      .bar_i   (bar_nxt),
      .en_o    (win_en_o),
      .len_o   (win_len_o),
      .base_o  (win_base_o),
      .err_o   (len_err_o)
   );

   cfgwin_hit #(
      .ADDR_W (ADDR_W)
   ) u_hit (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_vld_i (addr_vld_i),
      .addr_i     (addr_i),
      .en_i       (win_en_o),
      .len_i      (win_len_o),
      .base_i     (win_base_o),
      .hit_o      (hit_o),
      .bus_o      (bus_o),
      .dev_o      (dev_o),
      .fn_o       (fn_o),
      .off_o      (reg_off_o)
   );

endmodule

// File: rtl/cfgwin_decoder_chk.sv
module cfgwin_decoder_chk #(
   parameter int unsigned ADDR_W = 40
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr_vld_i,
   input logic              addr_vld_i,
   input logic              win_en_o,
   input logic [1:0]        win_len_o,
   input logic [ADDR_W-1:0] win_base_o,
   input logic              len_err_o,
   input logic              hit_o,
   input logic [7:0]        bus_o,
   input logic [4:0]        dev_o,
   input logic [2:0]        fn_o,
   input logic [11:0]       reg_off_o
);

   // R8
   hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> $past(win_en_o));

   // R7
   hit_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> $past(addr_vld_i));

   // R9
   idle_fields_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_o |-> (bus_o == 8'd0 && dev_o == 5'd0 && fn_o == 3'd0 && reg_off_o == 12'd0));

   // R2
   len_never_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_len_o != 2'b11);

   // R3
   base_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_base_o[25:0] == 26'd0);

   // R3
   base_256_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_len_o == 2'b00) |-> (win_base_o[27:26] == 2'b00));

   // R3
   base_128_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_len_o == 2'b01) |-> (win_base_o[26] == 1'b0));

   // R4
   rsvd_keeps_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      len_err_o |-> ($stable(win_en_o) && $stable(win_len_o) && $stable(win_base_o)));

   // R10
   err_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      len_err_o |-> $past(cfg_wr_vld_i));

   // R6
   window_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_wr_vld_i) |-> ($stable(win_en_o) && $stable(win_len_o) && $stable(win_base_o)));

endmodule

bind cfgwin_decoder cfgwin_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_wr_vld_i (cfg_wr_vld_i),
   .addr_vld_i   (addr_vld_i),
   .win_en_o     (win_en_o),
   .win_len_o    (win_len_o),
   .win_base_o   (win_base_o),
   .len_err_o    (len_err_o),
   .hit_o        (hit_o),
   .bus_o        (bus_o),
   .dev_o        (dev_o),
   .fn_o         (fn_o),
   .reg_off_o    (reg_off_o)
);

// File: tb/cfgwin_decoder_tb.sv
module cfgwin_decoder_tb;

   localparam int unsigned ADDR_W    = 40;
   localparam int unsigned BASE_MSB  = 35;
   localparam int unsigned CFG_DW_AW = 10;
   localparam int unsigned REG_DW    = 24;
   localparam logic [63:0] DEF_VAL   = 64'h0000_0000_B000_0000;
   localparam time         CLK_PERIOD = 10ns;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 cfg_wr_vld = 1'b0;
   logic [CFG_DW_AW-1:0] cfg_wr_dw = '0;
   logic [3:0]           cfg_wr_be = '0;
   logic [31:0]          cfg_wr_data = '0;
   logic                 addr_vld = 1'b0;
   logic [ADDR_W-1:0]    addr = '0;
   logic                 win_en;
   logic [1:0]           win_len;
   logic [ADDR_W-1:0]    win_base;
   logic                 len_err;
   logic                 hit;
   logic [7:0]           bus;
   logic [4:0]           dev;
   logic [2:0]           fn;
   logic [11:0]          reg_off;

   int unsigned n_chk = 0;
   int unsigned n_err = 0;
   bit          done  = 1'b0;

   // bench model
   logic [63:0]       m_reg;
   logic              m_en;
   logic [1:0]        m_len;
   logic [ADDR_W-1:0] m_base;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfgwin_decoder #(
      .ADDR_W(ADDR_W), .BASE_MSB(BASE_MSB), .CFG_DW_AW(CFG_DW_AW),
      .REG_DW(REG_DW), .DEFAULT_VAL(DEF_VAL)
   ) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr_vld_i(cfg_wr_vld), .cfg_wr_dw_i(cfg_wr_dw),
      .cfg_wr_be_i(cfg_wr_be), .cfg_wr_data_i(cfg_wr_data),
      .addr_vld_i(addr_vld), .addr_i(addr),
      .win_en_o(win_en), .win_len_o(win_len), .win_base_o(win_base),
      .len_err_o(len_err), .hit_o(hit), .bus_o(bus), .dev_o(dev),
      .fn_o(fn), .reg_off_o(reg_off)
   );

   function automatic int unsigned exp_shift(input logic [1:0] l);
      return (l == 2'b00) ? 28 : (l == 2'b01) ? 27 : 26;
   endfunction

   function automatic logic [ADDR_W-1:0] exp_base(input logic [63:0] r);
      logic [ADDR_W-1:0] b;
      int unsigned sh;
      sh = exp_shift(r[2:1]);
      b = '0;
      for (int i = 0; i < ADDR_W; i++)
         if (i >= int'(sh) && i <= int'(BASE_MSB)) b[i] = r[i];
      return b;
   endfunction

   function automatic logic [ADDR_W-1:0] span_mask(input logic [1:0] l);
      return (ADDR_W'(1) << exp_shift(l)) - ADDR_W'(1);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic check_window(input string req);
      chk(win_en == m_en, req, "enable", 64'(win_en), 64'(m_en));
      chk(win_len == m_len, req, "length", 64'(win_len), 64'(m_len));
      chk(win_base == m_base, req, "base", 64'(win_base), 64'(m_base));
   endtask

   task automatic cfg_write(input logic [CFG_DW_AW-1:0] dw, input logic [3:0] be,
                            input logic [31:0] data, input string req);
      bit touched;
      bit e_err;
      @(negedge clk);
      cfg_wr_vld = 1'b1; cfg_wr_dw = dw; cfg_wr_be = be; cfg_wr_data = data;
      @(negedge clk);
      cfg_wr_vld = 1'b0;
      touched = 1'b0;
      for (int h = 0; h < 2; h++) begin
         if (dw == CFG_DW_AW'(REG_DW + h)) begin
            for (int b = 0; b < 4; b++) begin
               if (be[b]) begin
                  m_reg[h*32 + b*8 +: 8] = data[b*8 +: 8];
                  touched = 1'b1;
               end
            end
         end
      end
      e_err = touched && (m_reg[2:1] == 2'b11);
      if (touched && !e_err) begin
         m_en = m_reg[0]; m_len = m_reg[2:1]; m_base = exp_base(m_reg);
      end
      // R5 R6 R4: window after the write
      check_window(req);
      // R10 R4: error pulse
      chk(len_err == e_err, e_err ? "R4" : "R10", "len_err", 64'(len_err), 64'(e_err));
   endtask

   task automatic probe(input logic [ADDR_W-1:0] a, input bit vld, input string req);
      bit e_hit;
      logic [7:0] e_bus;
      @(negedge clk);
      addr_vld = vld; addr = a;
      @(negedge clk);
      addr_vld = 1'b0;
      e_hit = vld && m_en && (((a ^ m_base) & ~span_mask(m_len)) == '0);
      e_bus = a[27:20];
      if (m_len == 2'b01) e_bus[7] = 1'b0;
      if (m_len == 2'b10) e_bus[7:6] = 2'b00;
      chk(hit == e_hit, req, "hit", 64'(hit), 64'(e_hit));
      // R9: fields, zero on a miss
      chk(bus == (e_hit ? e_bus : 8'd0), "R9", "bus", 64'(bus), 64'(e_hit ? e_bus : 8'd0));
      chk(dev == (e_hit ? a[19:15] : 5'd0), "R9", "dev", 64'(dev), 64'(e_hit ? a[19:15] : 5'd0));
      chk(fn == (e_hit ? a[14:12] : 3'd0), "R9", "fn", 64'(fn), 64'(e_hit ? a[14:12] : 3'd0));
      chk(reg_off == (e_hit ? a[11:0] : 12'd0), "R9", "reg_off", 64'(reg_off),
          64'(e_hit ? a[11:0] : 12'd0));
   endtask

   function automatic logic [ADDR_W-1:0] rnd_addr();
      return ADDR_W'({$urandom(), $urandom()});
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20241));
      m_reg = DEF_VAL; m_en = DEF_VAL[0]; m_len = DEF_VAL[2:1]; m_base = exp_base(DEF_VAL);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(win_en == 1'b0, "R1", "reset enable", 64'(win_en), 64'd0);
      chk(win_len == 2'b00, "R1", "reset length", 64'(win_len), 64'd0);
      chk(win_base == ADDR_W'(40'hB000_0000), "R1", "reset base", 64'(win_base), 64'hB000_0000);
      chk(hit == 1'b0 && len_err == 1'b0, "R1", "reset hit/err", 64'(hit), 64'd0);
      // R8: disabled window never hits
      probe(ADDR_W'(40'hB012_3456), 1'b1, "R8");
      // R2 R5: enable 256 MiB at 0xB000_0000 via a single byte lane
      cfg_write(CFG_DW_AW'(REG_DW), 4'b0001, 32'h0000_0001, "R2");
      probe(ADDR_W'(40'hB000_0000) | ADDR_W'(8'hA5) << 20 | ADDR_W'(5'd3) << 15
            | ADDR_W'(3'd2) << 12 | ADDR_W'(12'h10), 1'b1, "R7");
      probe(ADDR_W'(40'hBFFF_FFFC), 1'b1, "R7");
      probe(ADDR_W'(40'hC000_0000), 1'b1, "R7");
      probe(ADDR_W'(40'hAFFF_FFFF), 1'b1, "R7");
      probe(ADDR_W'(40'h10_B000_0000), 1'b1, "R7");
      // R8: no strobe, no hit
      probe(ADDR_W'(40'hB000_1000), 1'b0, "R8");
      // R3: high dword base bits and 128 MiB
      cfg_write(CFG_DW_AW'(REG_DW + 1), 4'b0001, 32'h0000_0005, "R3");
      cfg_write(CFG_DW_AW'(REG_DW), 4'b1111, 32'hE800_0003, "R3");
      probe(ADDR_W'(40'h5_EFF0_0000), 1'b1, "R7");
      probe(ADDR_W'(40'h5_F000_0000), 1'b1, "R7");
      // R3: 64 MiB with base bit 26 set
      cfg_write(CFG_DW_AW'(REG_DW), 4'b1111, 32'hE400_0005, "R3");
      probe(ADDR_W'(40'h5_E7FF_F123), 1'b1, "R9");
      probe(ADDR_W'(40'h5_E3FF_FFFF), 1'b1, "R7");
      // R4: reserved code keeps the window
      cfg_write(CFG_DW_AW'(REG_DW), 4'b0001, 32'h0000_0007, "R4");
      probe(ADDR_W'(40'h5_E400_0000), 1'b1, "R4");
      // R6: neighbours and empty byte enables leave the window
      cfg_write(CFG_DW_AW'(REG_DW + 2), 4'b1111, 32'h0000_0000, "R6");
      cfg_write(CFG_DW_AW'(REG_DW - 1), 4'b1111, 32'h0000_0000, "R6");
      cfg_write(CFG_DW_AW'(REG_DW), 4'b0000, 32'h0000_0000, "R6");
      // R5: repair the length, then disable
      cfg_write(CFG_DW_AW'(REG_DW), 4'b0001, 32'h0000_0001, "R5");
      cfg_write(CFG_DW_AW'(REG_DW), 4'b0001, 32'h0000_0000, "R5");
      probe(ADDR_W'(40'h5_E000_0000), 1'b1, "R8");
      // random mix
      for (int it = 0; it < 300; it++) begin
         int unsigned pick;
         pick = $urandom_range(0, 5);
         case (pick)
            0, 1, 2: cfg_write(CFG_DW_AW'(REG_DW), 4'($urandom()), $urandom(), "R5");
            3:       cfg_write(CFG_DW_AW'(REG_DW + 1), 4'($urandom()), $urandom() & 32'hF, "R5");
            4:       cfg_write(CFG_DW_AW'(REG_DW + 2), 4'($urandom()), $urandom(), "R6");
            default: cfg_write(CFG_DW_AW'(REG_DW), 4'b0001, 32'h0000_0001 | ($urandom() & 32'h6), "R5");
         endcase
         for (int p = 0; p < 6; p++) begin
            logic [ADDR_W-1:0] a;
            if (p[0]) a = m_base | (rnd_addr() & span_mask(m_len));
            else      a = rnd_addr() & ADDR_W'(40'h0F_FFFF_FFFF);
            probe(a, 1'b1, "R7");
         end
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule